// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block collects small aligned stores and combines them into whole 64-byte lines before they reach a burst-capable memory bus. Each incoming store carries 128 bits of data, a 16-bit byte strobe and an address whose four low bits must be zero. Stores that land in the line currently held are merged byte by byte into a single line buffer, which keeps one valid bit per byte. A later store to a byte replaces the earlier value.

The held line is sent downstream as one four-beat burst of 128-bit beats. A burst starts when every byte of the line is valid, when a store arrives for a different line, or when the fence input is pulsed. A fence reports completion only when the buffer is empty and the burst carrying its data has been accepted. Stores to different lines can reach memory in an order other than the order they were issued. The block is meant for memory regions such as frame buffers, where strong ordering is not needed.

Top module: `wc_store_buffer`

## Requirements
- R1: After reset the buffer is empty. `st_ready` is high, and `bw_valid`, `fence_done` and `misalign_err` are low.
- R2: A store with `st_addr[3:0]` not zero is accepted and then dropped. `misalign_err` is high for the one cycle after the accepting edge, and the buffer contents do not change.
- R3: Aligned stores with equal `st_addr[31:6]` merge into one line. `st_addr[5:4]` selects the 16-byte unit, and only bytes whose strobe bit is set are written. A later write to a byte replaces the earlier value.
- R4: When all 64 bytes of the line are valid, a burst starts without any further request. `st_ready` is low from the cycle after the filling store until the burst completes.
- R5: While the line holds data, an aligned store to a different line is stalled (`st_ready` low). The held line is drained, and the stalled store is then accepted into the empty buffer.
- R6: A one-cycle `fence_req` pulse drains any held line. `fence_done` is high for one cycle, in the cycle after the last beat is accepted. If the buffer is already empty, `fence_done` rises in the second cycle after the pulse and no burst is issued.
- R7: A burst is exactly four beats. Beat i carries line bytes 16i to 16i+15, with `bw_strb` bit b set when line byte 16i+b is valid. `bw_addr` is the line base with bits 5:0 zero, and `bw_last` is high only on the fourth beat. A beat does not change while `bw_ready` is low.
- R8: `st_ready` is low while a burst is in progress and while a fence is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted this cycle when high with st_valid |
| st_addr | input | 32 | Store byte address, 16-byte aligned |
| st_data | input | 128 | Store data, byte b in bits 8b+7:8b |
| st_strb | input | 16 | Store byte strobes |
| fence_req | input | 1 | One-cycle pulse requesting a drain and completion report |
| fence_done | output | 1 | One-cycle pulse: the fence has completed |
| misalign_err | output | 1 | One-cycle pulse: a misaligned store was dropped |
| bw_valid | output | 1 | Burst beat valid |
| bw_ready | input | 1 | Burst beat accepted |
| bw_addr | output | 32 | Line base address of the burst |
| bw_data | output | 128 | Beat data |
| bw_strb | output | 16 | Beat byte strobes |
| bw_last | output | 1 | Final beat of the burst |

## Verification
Two events can coincide: a store acceptance and a fence request in the same cycle. The bench provokes this by raising `st_valid` and `fence_req` together on an empty buffer. It expects the store to be merged first and to appear in the burst the fence triggers, with `fence_done` following that burst's last beat. A second collision, between a conflicting-line store and an in-flight drain, is provoked by holding a store for another line while the bench drains the old line. The bench then checks that the old line comes out unchanged and that the new store lands afterwards.

// File: rtl/wc_pkg.sv
// Shared types for the write-combining store buffer.
package wc_pkg;
    // Drain sequencer phase.
    typedef enum logic {
        DR_IDLE  = 1'b0,
        DR_BURST = 1'b1
    } drain_state_e;
endpackage

// File: rtl/wc_line_buffer.sv
// Single line store with a per-byte valid mask.
// Assumes the writer never writes while a clear is requested,
// and that the tag is stable while the mask is nonzero.
module wc_line_buffer #(
    parameter int DATA_W = 128,
    parameter int BEATS  = 4,
    parameter int TAG_W  = 26,
    localparam int UB     = DATA_W / 8,
    localparam int LB     = UB * BEATS,
    localparam int UNIT_W = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [UNIT_W-1:0] wr_unit,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [UB-1:0]     wr_strb,
    input  logic              clr,
    input  logic [UNIT_W-1:0] rd_unit,
    output logic              occupied,
    output logic              full,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] rd_data,
    output logic [UB-1:0]     rd_strb
);
    logic [DATA_W-1:0] mem_q [BEATS];
    logic [LB-1:0]     mask_q;
    logic [TAG_W-1:0]  tag_q;
    logic [BEATS-1:0]  unit_full;

    // Byte-granular merge of store data into the addressed unit.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < UB; b++) begin
                if (wr_strb[b]) mem_q[wr_unit][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    // Valid-mask accumulation and clearing after a drain.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (clr)   mask_q <= '0;
        else if (wr_en) mask_q[wr_unit*UB +: UB] <= mask_q[wr_unit*UB +: UB] | wr_strb;
    end

    // Line tag capture on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     tag_q <= '0;
        else if (wr_en) tag_q <= wr_tag;
    end

    // Per-unit completeness flags.
    for (genvar u = 0; u < BEATS; u++) begin : g_unit
        assign unit_full[u] = &mask_q[u*UB +: UB];
    end

    assign occupied = |mask_q;
    assign full     = &unit_full;
    assign tag      = tag_q;
    assign rd_data  = mem_q[rd_unit];
    assign rd_strb  = mask_q[rd_unit*UB +: UB];

    // R4: a drain clear leaves the line empty
    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !occupied);
    // R3: merging never coincides with a drain clear
    a_r3_no_write_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && wr_en));
endmodule

// File: rtl/wc_drain_seq.sv
// Emits the held line as a fixed four-beat burst.
// Assumes the line contents and tag are frozen while busy.
module wc_drain_seq
    import wc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128,
    parameter int BEATS  = 4,
    parameter int TAG_W  = 26,
    localparam int UB       = DATA_W / 8,
    localparam int UNIT_W   = $clog2(BEATS),
    localparam int LINE_OFF = ADDR_W - TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [UB-1:0]     rd_strb,
    output logic [UNIT_W-1:0] rd_unit,
    output logic              busy,
    output logic              done,
    output logic              bw_valid,
    input  logic              bw_ready,
    output logic [ADDR_W-1:0] bw_addr,
    output logic [DATA_W-1:0] bw_data,
    output logic [UB-1:0]     bw_strb,
    output logic              bw_last
);
    drain_state_e      state_q;
    logic [UNIT_W-1:0] beat_q;
    logic              fire;

    assign busy     = (state_q == DR_BURST);
    assign rd_unit  = beat_q;
    assign bw_valid = busy;
    assign bw_addr  = {line_tag, {LINE_OFF{1'b0}}};
    assign bw_data  = rd_data;
    assign bw_strb  = rd_strb;
    assign bw_last  = busy && (beat_q == UNIT_W'(BEATS - 1));
    assign fire     = bw_valid && bw_ready;
    assign done     = fire && bw_last;

    // Burst phase and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
            beat_q  <= '0;
        end else if (state_q == DR_IDLE) begin
            if (start) begin
                state_q <= DR_BURST;
                beat_q  <= '0;
            end
        end else if (fire) begin
            if (bw_last) state_q <= DR_IDLE;
            else         beat_q  <= beat_q + 1'b1;
        end
    end

    // R7: a stalled beat holds its contents
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid && !bw_ready |=> bw_valid && $stable(bw_data) && $stable(bw_strb)
                                  && $stable(bw_last) && $stable(bw_addr));
    // R8: no new drain is requested while one is running
    a_r8_no_start_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/wc_ctrl.sv
// Upstream handshake, flush decision, fence and misalignment tracking.
// Assumes fence_req is a single-cycle pulse.
module wc_ctrl #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128,
    parameter int BEATS  = 4,
    localparam int UNIT_OFF = $clog2(DATA_W / 8),
    localparam int UNIT_W   = $clog2(BEATS),
    localparam int LINE_OFF = UNIT_OFF + UNIT_W,
    localparam int TAG_W    = ADDR_W - LINE_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              st_ready,
    input  logic              fence_req,
    input  logic              occupied,
    input  logic              full,
    input  logic [TAG_W-1:0]  tag,
    input  logic              busy,
    input  logic              drain_done,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [UNIT_W-1:0] wr_unit,
    output logic              drain_start,
    output logic              fence_done,
    output logic              misalign_err
);
    logic aligned, conflict, flush_need, accept, fence_fire;
    logic fence_pend_q, fence_done_q, err_q;

    assign aligned     = (st_addr[UNIT_OFF-1:0] == '0);
    assign wr_tag      = st_addr[ADDR_W-1:LINE_OFF];
    assign wr_unit     = st_addr[LINE_OFF-1:UNIT_OFF];
    assign conflict    = st_valid && aligned && occupied && (wr_tag != tag);
    assign flush_need  = occupied && (full || fence_pend_q || conflict);
    assign drain_start = !busy && flush_need;
    assign st_ready    = !busy && !fence_pend_q && !flush_need;
    assign accept      = st_valid && st_ready;
    assign wr_en       = accept && aligned;
    assign fence_fire  = fence_pend_q && ((!busy && !occupied) || drain_done);

    // Fence bookkeeping: pending until the line is out, then a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fence_pend_q <= 1'b0;
            fence_done_q <= 1'b0;
        end else begin
            fence_pend_q <= (fence_pend_q && !fence_fire) || fence_req;
            fence_done_q <= fence_fire;
        end
    end

    // Misaligned-store flag, one cycle after the dropped acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= accept && !aligned;
    end

    assign fence_done   = fence_done_q;
    assign misalign_err = err_q;

    // R8: upstream is stalled during a burst
    a_r8_ready_low_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !st_ready);
    // R6: fence completion implies the line has gone out
    a_r6_done_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> !occupied && !busy);
    // R2: a misaligned store never reaches the line buffer
    a_r2_bad_not_written: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |-> !$past(wr_en));
    // R5: a conflicting store is never merged into the held line
    a_r5_no_foreign_merge: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && occupied |-> wr_tag == tag);
endmodule

// File: rtl/wc_store_buffer.sv
// Write-combining store buffer top: merges aligned 16-byte stores into one
// 64-byte line and drains it as a four-beat burst. Ordering across lines is weak.
// Assumes fence_req is a one-cycle pulse.
module wc_store_buffer #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128,
    parameter int BEATS  = 4,
    localparam int UB       = DATA_W / 8,
    localparam int UNIT_W   = $clog2(BEATS),
    localparam int LINE_OFF = $clog2(UB) + UNIT_W,
    localparam int TAG_W    = ADDR_W - LINE_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [UB-1:0]     st_strb,
    input  logic              fence_req,
    output logic              fence_done,
    output logic              misalign_err,
    output logic              bw_valid,
    input  logic              bw_ready,
    output logic [ADDR_W-1:0] bw_addr,
    output logic [DATA_W-1:0] bw_data,
    output logic [UB-1:0]     bw_strb,
    output logic              bw_last
);
    logic              wr_en, occupied, full, busy, drain_done, drain_start;
    logic [TAG_W-1:0]  wr_tag, tag;
    logic [UNIT_W-1:0] wr_unit, rd_unit;
    logic [DATA_W-1:0] rd_data;
    logic [UB-1:0]     rd_strb;

    wc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_ready(st_ready), .fence_req(fence_req), .occupied(occupied),
        .full(full), .tag(tag), .busy(busy), .drain_done(drain_done),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_unit(wr_unit),
        .drain_start(drain_start), .fence_done(fence_done),
        .misalign_err(misalign_err)
    );

    wc_line_buffer #(.DATA_W(DATA_W), .BEATS(BEATS), .TAG_W(TAG_W)) u_line (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_unit(wr_unit),
        .wr_tag(wr_tag), .wr_data(st_data), .wr_strb(st_strb),
        .clr(drain_done), .rd_unit(rd_unit), .occupied(occupied),
        .full(full), .tag(tag), .rd_data(rd_data), .rd_strb(rd_strb)
    );

    wc_drain_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS), .TAG_W(TAG_W)) u_drain (
        .clk(clk), .rst_n(rst_n), .start(drain_start), .line_tag(tag),
        .rd_data(rd_data), .rd_strb(rd_strb), .rd_unit(rd_unit),
        .busy(busy), .done(drain_done), .bw_valid(bw_valid),
        .bw_ready(bw_ready), .bw_addr(bw_addr), .bw_data(bw_data),
        .bw_strb(bw_strb), .bw_last(bw_last)
    );

    // R7: the final beat is always a valid beat
    a_r7_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        bw_last |-> bw_valid);
endmodule

// File: tb/test_wc_store_buffer.sv
`timescale 1ns/1ps
module test_wc_store_buffer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0, st_ready;
    logic [31:0]  st_addr = '0;
    logic [127:0] st_data = '0;
    logic [15:0]  st_strb = '0;
    logic         fence_req = 1'b0, fence_done, misalign_err;
    logic         bw_valid, bw_ready = 1'b0, bw_last;
    logic [31:0]  bw_addr;
    logic [127:0] bw_data;
    logic [15:0]  bw_strb;

    int checks = 0, errors = 0, cyc = 0;

    // Reference line model built from the requirements.
    logic [7:0]  m_byte [64];
    logic [63:0] m_mask = '0;
    logic [25:0] m_tag = '0;

    wc_store_buffer i_wc_store_buffer (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_strb(st_strb),
        .fence_req(fence_req), .fence_done(fence_done), .misalign_err(misalign_err),
        .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr),
        .bw_data(bw_data), .bw_strb(bw_strb), .bw_last(bw_last)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog act %0d exp %0d", cyc, 20000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act %h exp %h", req, what, act, exp);
        end
    endtask

    // Issue one store at a negedge; returns at the negedge after acceptance.
    task automatic do_store(input logic [31:0] a, input logic [127:0] d, input logic [15:0] s);
        int t = 0;
        st_addr = a; st_data = d; st_strb = s; st_valid = 1'b1;
        #1;
        while (!st_ready && t < 200) begin @(negedge clk); #1; t++; end
        @(posedge clk);
        if (a[3:0] == 4'd0) begin
            for (int b = 0; b < 16; b++)
                if (s[b]) begin
                    m_byte[a[5:4]*16 + b] = d[b*8 +: 8];
                    m_mask[a[5:4]*16 + b] = 1'b1;
                end
            m_tag = a[31:6];
        end
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    // Drain one burst and compare it with the model (R7).
    task automatic collect(input bit want_fence, input int stall, input string req);
        int t = 0;
        logic [127:0] ed, hd;
        logic [15:0]  es, hs;
        while (!bw_valid && t < 50) begin @(negedge clk); t++; end
        chk(bw_valid, req, "burst start", {127'd0, bw_valid}, 128'd1);
        chk(bw_addr == {m_tag, 6'd0}, "R7", "line base address", {96'd0, bw_addr}, {96'd0, m_tag, 6'd0});
        for (int i = 0; i < 4; i++) begin
            if (stall > 0) begin
                hd = bw_data; hs = bw_strb;
                bw_ready = 1'b0;
                repeat (stall) @(negedge clk);
                chk(bw_valid && bw_data == hd && bw_strb == hs, "R7", "stalled beat stable",
                    bw_data, hd);
            end
            es = m_mask[i*16 +: 16];
            ed = '0;
            for (int b = 0; b < 16; b++) if (es[b]) ed[b*8 +: 8] = m_byte[i*16 + b];
            chk(bw_valid && bw_strb == es && (bw_data & {<<8{es}} ) == ed
                || bw_valid && bw_strb == es && masked(bw_data, es) == ed,
                "R7", $sformatf("beat %0d data/strobe", i), masked(bw_data, es), ed);
            chk(bw_last == (i == 3), "R7", $sformatf("beat %0d last", i), {127'd0, bw_last}, {127'd0, i == 3});
            bw_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            bw_ready = 1'b0;
        end
        if (want_fence)
            chk(fence_done, "R6", "fence done after last beat", {127'd0, fence_done}, 128'd1);
        m_mask = '0;
    endtask

    function automatic logic [127:0] masked(input logic [127:0] d, input logic [15:0] s);
        logic [127:0] r = '0;
        for (int b = 0; b < 16; b++) if (s[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    task automatic pulse_fence();
        fence_req = 1'b1;
        @(negedge clk);
        fence_req = 1'b0;
    endtask

    task automatic t_reset();
        chk(st_ready && !bw_valid && !fence_done && !misalign_err, "R1", "reset outputs",
            {124'd0, st_ready, bw_valid, fence_done, misalign_err}, 128'h8);
        pulse_fence();
        @(negedge clk);
        chk(fence_done && !bw_valid, "R1", "empty after reset: fence without burst",
            {126'd0, fence_done, bw_valid}, 128'h2);
    endtask

    task automatic t_merge();
        do_store(32'h0000_1000, {16{8'h11}}, 16'hFFFF);
        do_store(32'h0000_1020, {16{8'h22}}, 16'h00F0);
        do_store(32'h0000_1000, {16{8'h33}}, 16'h0F0F);
        chk(st_ready && !bw_valid, "R3", "partial line held", {126'd0, st_ready, bw_valid}, 128'h2);
        pulse_fence();
        chk(!st_ready, "R8", "ready low while fence pending", {127'd0, st_ready}, 128'd0);
        collect(1'b1, 0, "R3");
    endtask

    task automatic t_fence_empty();
        pulse_fence();
        chk(!fence_done, "R6", "empty fence not yet done", {127'd0, fence_done}, 128'd0);
        @(negedge clk);
        chk(fence_done && !bw_valid, "R6", "empty fence done without burst",
            {126'd0, fence_done, bw_valid}, 128'h2);
        @(negedge clk);
        chk(!fence_done, "R6", "done is one pulse", {127'd0, fence_done}, 128'd0);
    endtask

    task automatic t_full();
        for (int u = 0; u < 4; u++) do_store(32'h0000_2000 + u*16, {16{8'(8'hA0 + u)}}, 16'hFFFF);
        chk(!st_ready, "R4", "ready low after line fills", {127'd0, st_ready}, 128'd0);
        collect(1'b0, 0, "R4");
        chk(st_ready, "R4", "ready back after burst", {127'd0, st_ready}, 128'd1);
    endtask

    task automatic t_conflict();
        do_store(32'h0000_3010, {8{16'hBEEF}}, 16'h3C3C);
        st_addr = 32'h0000_4030; st_data = {16{8'h5A}}; st_strb = 16'hFFFF; st_valid = 1'b1;
        #1;
        chk(!st_ready, "R5", "conflicting store stalled", {127'd0, st_ready}, 128'd0);
        fork
            do_store(32'h0000_4030, {16{8'h5A}}, 16'hFFFF);
            collect(1'b0, 0, "R5");
        join
        chk(m_mask == 64'hFFFF_0000_0000_0000 && m_tag == 26'h100, "R5", "stalled store entered after drain",
            {64'd0, m_mask}, 128'hFFFF_0000_0000_0000);
        pulse_fence();
        collect(1'b1, 0, "R5");
    endtask

    task automatic t_misalign();
        do_store(32'h0000_5004, {16{8'hEE}}, 16'hFFFF);
        chk(misalign_err, "R2", "error flag after bad store", {127'd0, misalign_err}, 128'd1);
        @(negedge clk);
        chk(!misalign_err, "R2", "error flag is one pulse", {127'd0, misalign_err}, 128'd0);
        pulse_fence();
        @(negedge clk);
        chk(fence_done && !bw_valid, "R2", "dropped store left buffer empty",
            {126'd0, fence_done, bw_valid}, 128'h2);
    endtask

    task automatic t_stall();
        do_store(32'h0000_6000, {4{32'h0123_4567}}, 16'hF00F);
        do_store(32'h0000_6030, {4{32'h89AB_CDEF}}, 16'h0FF0);
        pulse_fence();
        collect(1'b1, 2, "R7");
    endtask

    task automatic t_same_cycle();
        st_addr = 32'h0000_7010; st_data = {16{8'h77}}; st_strb = 16'h00FF; st_valid = 1'b1;
        fence_req = 1'b1;
        #1;
        chk(st_ready, "R6", "store offered with fence", {127'd0, st_ready}, 128'd1);
        @(posedge clk);
        for (int b = 0; b < 8; b++) begin m_byte[16 + b] = 8'h77; m_mask[16 + b] = 1'b1; end
        m_tag = 26'h1C0;
        @(negedge clk);
        st_valid = 1'b0; fence_req = 1'b0;
        chk(!fence_done, "R6", "fence waits for same-cycle store", {127'd0, fence_done}, 128'd0);
        collect(1'b1, 0, "R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_merge();
        t_fence_empty();
        t_full();
        t_conflict();
        t_misalign();
        t_stall();
        t_same_cycle();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule